// File: doc/BRIEF.md
# Sticky Fault Status Register

This block gathers the flags raised by a sensor's fault detectors into one status word for the serial host interface. Detector lines may change at any time, so each one passes through a synchronizer before it touches the register. A flag that fires sets its bit, and the bit stays set, even after the detector goes quiet, until the host has completed a response frame that carried the register.

At the end of each frame the interface pulses a strobe. On that strobe every bit whose detector is quiet is cleared. A bit whose detector is still active stays set. The host therefore sees a fault that is still present again in the next exchange.

The register goes out with every sensor-data response. It can also be read at its own register address. A two-bit validity status goes with the rate data and marks the data as suspect whenever the summary failure bit is set. Two bits are derived rather than detected directly: the power bit is the OR of the over-voltage and under-voltage flags, and the failure bit is the OR of the detectors chosen to invalidate the data.

Top module: `fault_status_reg`

## Requirements
- R1: A detector level that is driven between clock edges and held shows in the register after the third rising clock edge that follows it. The delay is two synchronizer stages plus the latch.
- R2: A set bit stays set while the frame strobe is low, whatever its detector does.
- R3: On a rising edge where the frame strobe is high, every bit whose synchronized condition is low is cleared.
- R4: On a rising edge where the frame strobe is high, every bit whose synchronized condition is high is left set.
- R5: Detector input bits, from 0 to 9, are: pll, quadrature, memory checksum, init check, under-voltage, amplitude, self-test, check-mode, over-voltage and severe self-test. Register bits, from 0 to 10, are: pll, quadrature, memory, init, under-voltage, amplitude, power, self-test, check-mode, over-voltage and fail. Every direct bit latches its own detector.
- R6: The power bit (bit 6) latches when either the under-voltage detector or the over-voltage detector is active.
- R7: The self-test bit (bit 7) latches on either the self-test detector or the severe self-test detector.
- R8: The fail bit (bit 10) latches on the pll detector or the severe self-test detector. This is the default forcing mask.
- R9: The status output is 2'b00 while the fail bit is set, and the normal code 2'b01 otherwise.
- R10: The response fault output always equals the register. The read data equals the register, zero-extended, when the read address is 0x0A, and is zero for any other address.
- R11: While reset is held, and until a detector fires after reset, the register is zero, the read data is zero and the status shows the normal code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| det_i | input | 10 | Raw detector levels, asynchronous |
| frame_done_i | input | 1 | End-of-response strobe that clears quiet bits |
| rd_addr_i | input | 8 | Register read address |
| rd_data_o | output | 16 | Addressed read data |
| rsp_fault_o | output | 11 | Fault register appended to sensor-data responses |
| rsp_status_o | output | 2 | Rate-data validity status |

## Verification
A bit that is wrongly held or wrongly cleared shows on the response fault port on the very edge where the frame strobe is sampled. In the same cycle the read data at address 0x0A shows the same error. A fault in the fail or power derivation shows three edges after the detector changes, on both the register bit and the status code. A synchronizer that is one stage too short or too long shifts every change in the register by one cycle. A reference model that is compared on every clock catches this from the first detector pulse.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int DET_W = 10;
  localparam int REG_W = 11;

  // detector input positions
  localparam int D_PLL   = 0;
  localparam int D_QUAD  = 1;
  localparam int D_MEM   = 2;
  localparam int D_INIT  = 3;
  localparam int D_UNDER = 4;
  localparam int D_AMP   = 5;
  localparam int D_SELF  = 6;
  localparam int D_CHK   = 7;
  localparam int D_OVER  = 8;
  localparam int D_SEVERE = 9;

  // register bit positions
  localparam int F_PLL   = 0;
  localparam int F_QUAD  = 1;
  localparam int F_MEM   = 2;
  localparam int F_INIT  = 3;
  localparam int F_UNDER = 4;
  localparam int F_AMP   = 5;
  localparam int F_PWR   = 6;
  localparam int F_SELF  = 7;
  localparam int F_CHK   = 8;
  localparam int F_OVER  = 9;
  localparam int F_FAIL  = 10;

  typedef logic [DET_W-1:0] det_vec_t;
  typedef logic [REG_W-1:0] fault_vec_t;
endpackage

// File: rtl/fsr_sync.sv
module fsr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_comb stg_d[s] = d_i;
    end else begin : g_next
      always_comb stg_d[s] = stg_q[s-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_d[s];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/fsr_cond.sv
module fsr_cond
  import fsr_pkg::*;
#(
  parameter det_vec_t FORCE_MASK = det_vec_t'(10'b10_0000_0001)
) (
  input  det_vec_t   det_s_i,
  output fault_vec_t cond_o
);
  always_comb begin
    cond_o         = '0;
    cond_o[F_PLL]   = det_s_i[D_PLL];
    cond_o[F_QUAD]  = det_s_i[D_QUAD];
    cond_o[F_MEM]   = det_s_i[D_MEM];
    cond_o[F_INIT]  = det_s_i[D_INIT];
    cond_o[F_UNDER] = det_s_i[D_UNDER];
    cond_o[F_AMP]   = det_s_i[D_AMP];
    cond_o[F_PWR]   = det_s_i[D_UNDER] | det_s_i[D_OVER];
    cond_o[F_SELF]  = det_s_i[D_SELF] | det_s_i[D_SEVERE];
    cond_o[F_CHK]   = det_s_i[D_CHK];
    cond_o[F_OVER]  = det_s_i[D_OVER];
    cond_o[F_FAIL]  = |(det_s_i & FORCE_MASK);
  end
endmodule

// File: rtl/fsr_latch.sv
module fsr_latch #(
  parameter int W = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cond_i,
  input  logic         clr_i,
  output logic [W-1:0] sticky_o
);
  logic [W-1:0] sticky_q;
  logic [W-1:0] sticky_d;
  logic [W-1:0] bit_en;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_comb begin
      bit_en[b]   = cond_i[b] | clr_i;
      sticky_d[b] = cond_i[b] | (sticky_q[b] & ~clr_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        sticky_q[b] <= 1'b0;
      else if (bit_en[b]) sticky_q[b] <= sticky_d[b];
    end
  end

  assign sticky_o = sticky_q;

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));

  assert_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ((sticky_q & ~$past(cond_i)) == '0));

  assert_relatch_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ((sticky_q & $past(cond_i)) == $past(cond_i)));
endmodule

// File: rtl/fault_status_reg.sv
module fault_status_reg
  import fsr_pkg::*;
#(
  parameter int          SYNC_STAGES   = 2,
  parameter int          ADDR_W        = 8,
  parameter int          DATA_W        = 16,
  parameter logic [7:0]  FAULT_ADDR    = 8'h0A,
  parameter logic [1:0]  NORMAL_STATUS = 2'b01,
  parameter det_vec_t    FORCE_MASK    = det_vec_t'(10'b10_0000_0001)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DET_W-1:0]  det_i,
  input  logic              frame_done_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [REG_W-1:0]  rsp_fault_o,
  output logic [1:0]        rsp_status_o
);
  localparam int PAD_W = DATA_W - REG_W;
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(FAULT_ADDR);

  logic       rst_n_s;
  det_vec_t   det_s;
  fault_vec_t cond;
  fault_vec_t sticky;

  fsr_sync #(.W(1), .STAGES(2)) u_rst_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (1'b1),
    .q_o   (rst_n_s)
  );

  fsr_sync #(.W(DET_W), .STAGES(SYNC_STAGES)) u_det_sync (
    .clk_i (clk_i),
    .rst_ni(rst_n_s),
    .d_i   (det_i),
    .q_o   (det_s)
  );

  fsr_cond #(.FORCE_MASK(FORCE_MASK)) u_cond (
    .det_s_i(det_s),
    .cond_o (cond)
  );

  fsr_latch #(.W(REG_W)) u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_s),
    .cond_i  (cond),
    .clr_i   (frame_done_i),
    .sticky_o(sticky)
  );

  always_comb begin
    rsp_fault_o  = sticky;
    rsp_status_o = sticky[F_FAIL] ? 2'b00 : NORMAL_STATUS;
    rd_data_o    = '0;
    if (rd_addr_i == HIT_ADDR) rd_data_o = {{PAD_W{1'b0}}, sticky};
  end

  assert_power_R6: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (cond[F_UNDER] | cond[F_OVER]) |=> rsp_fault_o[F_PWR]);

  assert_status_R9: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    cond[F_FAIL] |=> (rsp_status_o == 2'b00));

  assert_read_R10: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (rd_addr_i != HIT_ADDR) |-> (rd_data_o == '0));
endmodule

// File: tb/fault_status_reg_tb.sv
module fault_status_reg_tb;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic [9:0]  det;
  logic        frame;
  logic [7:0]  addr;
  logic [15:0] rd_data;
  logic [10:0] rsp_fault;
  logic [1:0]  rsp_status;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fault_status_reg u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .det_i       (det),
    .frame_done_i(frame),
    .rd_addr_i   (addr),
    .rd_data_o   (rd_data),
    .rsp_fault_o (rsp_fault),
    .rsp_status_o(rsp_status)
  );

  // reference model
  logic [9:0]  pipe[$];
  logic [10:0] m_reg;

  function automatic logic [10:0] expand(logic [9:0] d);
    logic [10:0] r;
    r[0]  = d[0];
    r[1]  = d[1];
    r[2]  = d[2];
    r[3]  = d[3];
    r[4]  = d[4];
    r[5]  = d[5];
    r[6]  = d[4] | d[8];
    r[7]  = d[6] | d[9];
    r[8]  = d[7];
    r[9]  = d[8];
    r[10] = d[0] | d[9];
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_reg = '0;
      pipe = {10'd0, 10'd0};
    end else begin
      m_reg = expand(pipe[0]) | (frame ? 11'd0 : m_reg);
      void'(pipe.pop_front());
      pipe.push_back(det);
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    logic [15:0] exp_rd;
    exp_rd = (addr == 8'h0A) ? {5'd0, m_reg} : 16'd0;
    chk({tag, " fault reg"}, 32'(rsp_fault), 32'(m_reg));
    chk("R9 status", 32'(rsp_status), m_reg[10] ? 32'd0 : 32'd1);
    chk("R10 read data", 32'(rd_data), 32'(exp_rd));
  endtask

  task automatic step(string tag, logic [9:0] d, logic f, logic [7:0] a);
    @(negedge clk);
    compare(tag);
    det = d; frame = f; addr = a;
  endtask

  initial begin
    rst_ni = 1'b0; det = '0; frame = 1'b0; addr = 8'h0A;
    m_reg = '0; pipe = {10'd0, 10'd0};
    repeat (3) @(negedge clk);
    compare("R11");
    rst_ni = 1'b1;
    repeat (4) step("R11", 10'd0, 1'b0, 8'h0A);

    // R1/R5/R8: pll pulse for one cycle, latched and held
    step("R1", 10'b00_0000_0001, 1'b0, 8'h0A);
    step("R1", 10'd0, 1'b0, 8'h0A);
    step("R1", 10'd0, 1'b0, 8'h0A);
    step("R1", 10'd0, 1'b0, 8'h0A);
    chk("R1 pll latched", 32'(rsp_fault[0]), 32'd1);
    chk("R8 fail from pll", 32'(rsp_fault[10]), 32'd1);
    repeat (5) step("R2", 10'd0, 1'b0, 8'h0A);
    // R3: clear with quiet detector
    step("R3", 10'd0, 1'b1, 8'h0A);
    step("R3", 10'd0, 1'b0, 8'h0A);
    chk("R3 cleared", 32'(rsp_fault), 32'd0);

    // R4/R6: persistent under-voltage across a read
    step("R6", 10'b00_0001_0000, 1'b0, 8'h0A);
    repeat (4) step("R6", 10'b00_0001_0000, 1'b0, 8'h0A);
    step("R4", 10'b00_0001_0000, 1'b1, 8'h0A);
    step("R4", 10'b00_0001_0000, 1'b0, 8'h0A);
    chk("R4 relatched", 32'(rsp_fault[6:4]), 32'b101);
    step("R4", 10'd0, 1'b0, 8'h0A);
    repeat (3) step("R2", 10'd0, 1'b0, 8'h0A);
    step("R3", 10'd0, 1'b1, 8'h0A);
    step("R3", 10'd0, 1'b0, 8'h0A);

    // R6 over, R7/R8 severe, R5 each direct bit, R10 other address
    step("R6", 10'b01_0000_0000, 1'b0, 8'h03);
    repeat (4) step("R6", 10'd0, 1'b0, 8'h03);
    step("R7", 10'b10_0000_0000, 1'b1, 8'h0A);
    repeat (4) step("R7", 10'd0, 1'b0, 8'h0A);
    step("R7", 10'b00_0100_0000, 1'b1, 8'h0A);
    repeat (4) step("R7", 10'd0, 1'b0, 8'h0A);
    for (int i = 0; i < 10; i++) begin
      step("R5", 10'd1 << i, 1'b1, 8'h0A);
      repeat (3) step("R5", 10'd0, 1'b0, 8'h0B);
    end

    // random mix
    for (int n = 0; n < 3000; n++)
      step("R2", 10'($urandom), ($urandom % 5) == 0, ($urandom % 3 == 0) ? 8'h0A : 8'($urandom));

    step("R2", 10'd0, 1'b0, 8'h0A);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule